// File: doc/BRIEF.md
# Arbitrary Waveform Playback Channel

This block is a single output channel of an arbitrary waveform generator. A host writes 12-bit samples into an on-chip sample buffer through a small register write port. A start event, either a software command or a rising edge on an external trigger line, arms a start-delay timer. The timer counts in microsecond ticks. When it expires, the channel presents one sample per update period on a parallel DAC bus with a one-cycle strobe.

Four playback modes are available. Single-shot plays the buffer once and consumes it. Loop replays the stored waveform from its start without consuming it, using a replay offset against the loaded length. The two streaming modes consume samples continuously, so the host can keep the buffer topped up. The polling variant only reports level flags. The interrupt variant also raises a request when the buffer drains to half its depth, which tells the host that half of the space is free to refill. If a streaming channel runs dry, the DAC holds its last value and a sticky error bit is set. A command write clears both the interrupt and the error.

Top module: `wavegen_channel`

## Requirements
- R1: After reset, dac_data is 0, dac_strobe, irq, busy and underrun are 0, and empty_flag is 1.
- R2: Writing a command (address 4) with bit 0 set while idle starts the channel. The first sample strobe appears D*TICK_DIV+2 clock edges after the edge that takes the write, where D is the delay register at address 1.
- R3: Successive strobes are spaced by the period register (address 2) in clock cycles. A value below MIN_PERIOD is treated as MIN_PERIOD.
- R4: In mode 0 (single-shot; control register address 0, bits 1:0), each loaded sample is played once in load order and consumed. The channel then returns to idle with underrun left at 0.
- R5: In mode 1 (loop), the stored samples are replayed cyclically in load order without being consumed. Command bit 2 (abort) stops playback and leaves the data in the buffer.
- R6: In mode 2 (polling), samples are consumed. half_flag is 1 exactly when the buffer holds at most DEPTH/2 samples, empty_flag reflects an empty buffer, and irq is never raised.
- R7: In mode 3 (interrupt), irq rises after the strobe that leaves exactly DEPTH/2 samples in the buffer. It stays high until a command write with bit 1 (acknowledge).
- R8: In modes 2 and 3, an update slot that finds the buffer empty produces no strobe and leaves dac_data unchanged. It sets underrun, which stays set until a command write with bit 1.
- R9: When control bit 2 is set, a rising edge on ext_trig starts an idle channel SYNC_STAGES cycles later than a command start would. When control bit 2 is clear, ext_trig is ignored.
- R10: A sample write (address 3, bits 11:0) is dropped when the buffer already holds DEPTH samples.
- R11: While busy, control writes and start commands have no effect on the running playback.
- R12: Command bit 3 empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register address |
| wr_data | input | BUS_W | Register write data |
| ext_trig | input | 1 | External start input, asynchronous |
| dac_data | output | DATA_W | Current DAC sample |
| dac_strobe | output | 1 | One-cycle pulse when dac_data takes a new sample |
| irq | output | 1 | Half-drained interrupt request, interrupt mode only |
| busy | output | 1 | Channel is waiting out the delay or playing |
| half_flag | output | 1 | Buffer holds at most DEPTH/2 samples |
| empty_flag | output | 1 | Buffer holds no samples |
| underrun | output | 1 | Sticky: a streaming slot found the buffer empty |

## Verification
A wrong read pointer or a wrong replay offset shows on the next strobe as a value out of load order, so the scoreboard catches it within one update period. A wrong count shows in one of three ways: irq or half_flag changes on the wrong strobe, a sample that should have been dropped gets played, or a buffer that should be empty gets played. A timing fault in the delay or period counters moves the first strobe or the spacing between strobes by at least one cycle. The bench checks every strobe's cycle against the value it computes itself.

// File: rtl/wg_pkg.sv
package wg_pkg;
   typedef enum logic [1:0] {
      MODE_ONCE = 2'd0,
      MODE_LOOP = 2'd1,
      MODE_POLL = 2'd2,
      MODE_IRQ  = 2'd3
   } wg_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_PLAY = 2'd2
   } wg_state_e;

   localparam logic [2:0] REG_CTRL   = 3'd0;
   localparam logic [2:0] REG_DELAY  = 3'd1;
   localparam logic [2:0] REG_PERIOD = 3'd2;
   localparam logic [2:0] REG_DATA   = 3'd3;
   localparam logic [2:0] REG_CMD    = 3'd4;

   localparam int CMD_START = 0;
   localparam int CMD_ACK   = 1;
   localparam int CMD_ABORT = 2;
   localparam int CMD_FLUSH = 3;
   localparam int CTRL_EXT  = 2;
endpackage

// File: rtl/wg_fifo.sv
module wg_fifo #(
   parameter int DW    = 12,
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   input  logic          loop_mode,
   input  logic          loop_step,
   input  logic          loop_rst,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] count
);
   initial begin
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0)
         $fatal(1, "wg_fifo: DEPTH must be a power of two of at least 4");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, rd_idx;
   logic [CW-1:0] roff;
   logic          push_ok, pop_ok;

   assign push_ok = push && !flush && (count != CW'(DEPTH));
   assign pop_ok  = pop && !flush && (count != '0);

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush || loop_rst) roff <= '0;
      else if (loop_step)               roff <= (roff + 1'b1 >= count) ? '0 : roff + 1'b1;
   end

   assign rd_idx  = rd_ptr + (loop_mode ? roff[AW-1:0] : '0);
   assign rd_data = mem[rd_idx];

   a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   a_r10_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop && !flush && count == CW'(DEPTH) |=> count == CW'(DEPTH));
   a_r5_loop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      loop_step && !pop && !push && !flush |=> $stable(count));
endmodule

// File: rtl/wg_delay.sv
module wg_delay #(
   parameter int TW       = 32,
   parameter int TICK_DIV = 200,
   localparam int PW      = $clog2(TICK_DIV)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [TW-1:0] load_val,
   output logic          done
);
   initial begin
      if (TICK_DIV < 2) $fatal(1, "wg_delay: TICK_DIV must be at least 2");
   end

   logic [PW-1:0] tick;
   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick <= '0;
         cnt  <= '0;
      end else if (!run) begin
         tick <= '0;
         cnt  <= load_val;
      end else if (cnt != '0) begin
         if (tick == PW'(TICK_DIV - 1)) begin
            tick <= '0;
            cnt  <= cnt - 1'b1;
         end else begin
            tick <= tick + 1'b1;
         end
      end
   end

   assign done = run && (cnt == '0);

   a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      run && cnt != '0 |=> !run || cnt <= $past(cnt));
endmodule

// File: rtl/wg_pacer.sv
module wg_pacer #(
   parameter int PERW       = 16,
   parameter int MIN_PERIOD = 200
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PERW-1:0] period,
   output logic            fire
);
   initial begin
      if (MIN_PERIOD < 2 || MIN_PERIOD >= (1 << PERW))
         $fatal(1, "wg_pacer: MIN_PERIOD out of range");
   end

   logic [PERW-1:0] eff, cnt;

   assign eff = (period < PERW'(MIN_PERIOD)) ? PERW'(MIN_PERIOD) : period;

   always_ff @(posedge clk) begin
      if (!rst_n || !run)  cnt <= '0;
      else if (cnt == '0)  cnt <= eff - 1'b1;
      else                 cnt <= cnt - 1'b1;
   end

   assign fire = run && (cnt == '0);

   a_r3_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
endmodule

// File: rtl/wavegen_channel.sv
module wavegen_channel
   import wg_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int DEPTH       = 2048,
   parameter int DELAY_W     = 32,
   parameter int PERIOD_W    = 16,
   parameter int TICK_DIV    = 200,
   parameter int MIN_PERIOD  = 200,
   parameter int SYNC_STAGES = 2,
   parameter int REG_AW      = 3,
   parameter int BUS_W       = 32,
   localparam int CW         = $clog2(DEPTH) + 1,
   localparam int HALF       = DEPTH / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              ext_trig,
   output logic [DATA_W-1:0] dac_data,
   output logic              dac_strobe,
   output logic              irq,
   output logic              busy,
   output logic              half_flag,
   output logic              empty_flag,
   output logic              underrun
);
   initial begin
      if (BUS_W < DELAY_W || BUS_W < DATA_W || BUS_W < PERIOD_W || BUS_W < 4)
         $fatal(1, "wavegen_channel: BUS_W too narrow");
      if (REG_AW < 3) $fatal(1, "wavegen_channel: REG_AW must be at least 3");
   end

   wg_state_e           state;
   wg_mode_e            mode_q;
   logic                ext_en_q;
   logic [DELAY_W-1:0]  delay_q;
   logic [PERIOD_W-1:0] period_q;
   logic                w_ctrl, w_delay, w_period, w_data, w_cmd;
   logic                c_start, c_ack, c_abort, c_flush;
   logic                ext_s, ext_prev, ext_rise, start;
   logic                dly_done, fire, play_slot, streaming;
   logic [DATA_W-1:0]   rd_data;
   logic [CW-1:0]       count;

   assign w_ctrl   = wr_en && wr_addr == REG_AW'(REG_CTRL);
   assign w_delay  = wr_en && wr_addr == REG_AW'(REG_DELAY);
   assign w_period = wr_en && wr_addr == REG_AW'(REG_PERIOD);
   assign w_data   = wr_en && wr_addr == REG_AW'(REG_DATA);
   assign w_cmd    = wr_en && wr_addr == REG_AW'(REG_CMD);
   assign c_start  = w_cmd && wr_data[CMD_START];
   assign c_ack    = w_cmd && wr_data[CMD_ACK];
   assign c_abort  = w_cmd && wr_data[CMD_ABORT];
   assign c_flush  = w_cmd && wr_data[CMD_FLUSH];

   // External start: optional synchronizer chain picked by SYNC_STAGES
   if (SYNC_STAGES == 0) begin : g_nosync
      assign ext_s = ext_trig;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh <= '0;
         else        sh <= SYNC_STAGES'({sh, ext_trig});
      end
      assign ext_s = sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ext_prev <= 1'b0;
      else        ext_prev <= ext_s;
   end

   assign ext_rise  = ext_en_q && ext_s && !ext_prev;
   assign start     = (state == ST_IDLE) && (c_start || ext_rise);
   assign streaming = (mode_q == MODE_POLL) || (mode_q == MODE_IRQ);
   assign play_slot = (state == ST_PLAY) && fire && !c_abort;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_ONCE;
         ext_en_q <= 1'b0;
         delay_q  <= '0;
         period_q <= '0;
      end else begin
         if (w_ctrl && state == ST_IDLE) begin
            mode_q   <= wg_mode_e'(wr_data[1:0]);
            ext_en_q <= wr_data[CTRL_EXT];
         end
         if (w_delay)  delay_q  <= wr_data[DELAY_W-1:0];
         if (w_period) period_q <= wr_data[PERIOD_W-1:0];
      end
   end

   wg_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (c_flush),
      .push      (w_data),
      .push_data (wr_data[DATA_W-1:0]),
      .pop       (play_slot && mode_q != MODE_LOOP),
      .loop_mode (mode_q == MODE_LOOP),
      .loop_step (play_slot && mode_q == MODE_LOOP),
      .loop_rst  (start),
      .rd_data   (rd_data),
      .count     (count)
   );

   wg_delay #(.TW(DELAY_W), .TICK_DIV(TICK_DIV)) u_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state == ST_WAIT),
      .load_val (delay_q),
      .done     (dly_done)
   );

   wg_pacer #(.PERW(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_pacer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state == ST_PLAY),
      .period (period_q),
      .fire   (fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE: if (start) state <= ST_WAIT;
            ST_WAIT: if (c_abort) state <= ST_IDLE;
                     else if (dly_done) state <= ST_PLAY;
            ST_PLAY: if (c_abort) state <= ST_IDLE;
                     else if (play_slot && count == '0 && !streaming) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dac_data   <= '0;
         dac_strobe <= 1'b0;
         irq        <= 1'b0;
         underrun   <= 1'b0;
      end else begin
         dac_strobe <= play_slot && count != '0;
         if (play_slot && count != '0) dac_data <= rd_data;
         if (play_slot && count == '0 && streaming) underrun <= 1'b1;
         else if (c_ack)                            underrun <= 1'b0;
         if (play_slot && mode_q == MODE_IRQ && count == CW'(HALF + 1)) irq <= 1'b1;
         else if (c_ack)                                                 irq <= 1'b0;
      end
   end

   assign busy       = (state != ST_IDLE);
   assign half_flag  = (count <= CW'(HALF));
   assign empty_flag = (count == '0);

   a_r7_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> mode_q == MODE_IRQ);
   a_r6_poll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == MODE_POLL && !irq |=> !irq);
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      underrun && !c_ack |=> underrun);
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_data) |-> dac_strobe);
   a_r11_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mode_q));
   a_r2_strobe_in_play: assert property (@(posedge clk) disable iff (!rst_n)
      dac_strobe |-> $past(state) == ST_PLAY);
endmodule

// File: tb/wavegen_channel_tb.sv
`timescale 1ns/1ps
module wavegen_channel_tb;
   localparam int DEPTH = 16;
   localparam int TICK  = 4;
   localparam int MINP  = 4;
   localparam int SYNC  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        ext_trig = 1'b0;
   logic [11:0] dac_data;
   logic        dac_strobe, irq, busy, half_flag, empty_flag, underrun;

   always #2.5 clk = ~clk;

   wavegen_channel #(.DATA_W(12), .DEPTH(DEPTH), .DELAY_W(32), .PERIOD_W(16),
      .TICK_DIV(TICK), .MIN_PERIOD(MINP), .SYNC_STAGES(SYNC), .REG_AW(3), .BUS_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ext_trig(ext_trig), .dac_data(dac_data), .dac_strobe(dac_strobe), .irq(irq),
      .busy(busy), .half_flag(half_flag), .empty_flag(empty_flag), .underrun(underrun));

   int total = 0, bad = 0;
   int cyc = 0, last_edge = 0, sb_cnt = 0, prev_cyc = 0, exp_first = 0, exp_per = 0;
   bit arm_first = 0;
   string cur_tag = "R4";
   logic [11:0] exp_q [$];
   logic [11:0] last_v;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && dac_strobe) begin
         sb_cnt++;
         if (exp_q.size() == 0) chk(1'b0, {cur_tag, " unexpected strobe"}, dac_data, 0);
         else begin
            logic [11:0] e;
            e = exp_q.pop_front();
            chk(dac_data == e, cur_tag, dac_data, e);
         end
         if (arm_first) begin
            chk(cyc == exp_first, "R2 first strobe cycle", cyc, exp_first);
            arm_first = 0;
         end else if (exp_per != 0) begin
            chk(cyc - prev_cyc == exp_per, "R3 strobe spacing", cyc - prev_cyc, exp_per);
         end
         prev_cyc = cyc;
      end
   end

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      last_edge = cyc;
      wr_en = 1'b0;
   endtask

   task automatic load(input logic [11:0] v, input bit expect_it);
      reg_wr(3'd3, {20'd0, v});
      if (expect_it) exp_q.push_back(v);
      last_v = v;
   endtask

   task automatic soft_start(input int d);
      reg_wr(3'd4, 32'h1);
      exp_first = last_edge + d * TICK + 2;
      arm_first = 1;
   endtask

   task automatic ext_pulse(input int d, input bit expect_run);
      @(negedge clk); ext_trig = 1'b1;
      @(posedge clk); #1;
      if (expect_run) begin
         exp_first = cyc + SYNC + d * TICK + 2;
         arm_first = 1;
      end
      repeat (3) @(negedge clk);
      ext_trig = 1'b0;
   endtask

   task automatic wait_sb(input int n);
      int t = 0;
      while (sb_cnt < n && t < 5000) begin @(posedge clk); #1; t++; end
   endtask

   task automatic wait_idle();
      int t = 0;
      @(posedge clk); #1;
      while (busy && t < 5000) begin @(posedge clk); #1; t++; end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL R0 watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int b;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(dac_data == 0 && !dac_strobe, "R1 dac outputs", dac_data, 0);
      chk(!irq && !busy && !underrun, "R1 flags", {irq, busy, underrun}, 0);
      chk(empty_flag == 1, "R1 empty", empty_flag, 1);
      rst_n = 1'b1;

      // R4 single shot with delay 2, period 6
      cur_tag = "R4";
      reg_wr(3'd0, 32'd0);
      reg_wr(3'd1, 32'd2);
      reg_wr(3'd2, 32'd6);
      exp_per = 6;
      for (int i = 0; i < 5; i++) load(12'h100 + 12'(i * 37), 1);
      soft_start(2);
      wait_idle();
      chk(exp_q.size() == 0, "R4 all samples played", exp_q.size(), 0);
      chk(empty_flag == 1 && underrun == 0, "R4 consumed no underrun", {empty_flag, underrun}, 2);

      // R3 clamp: period 1 -> MIN_PERIOD, delay 0
      cur_tag = "R3";
      reg_wr(3'd1, 32'd0);
      reg_wr(3'd2, 32'd1);
      exp_per = MINP;
      for (int i = 0; i < 3; i++) load(12'hA00 + 12'(i), 1);
      soft_start(0);
      wait_idle();
      chk(exp_q.size() == 0, "R3 clamp run complete", exp_q.size(), 0);

      // R5 loop mode with R11 busy writes
      cur_tag = "R5";
      reg_wr(3'd0, 32'd1);
      reg_wr(3'd2, 32'd4);
      exp_per = 4;
      load(12'h0AA, 0); load(12'h0BB, 0); load(12'h0CC, 0);
      for (int i = 0; i < 7; i++) exp_q.push_back(i % 3 == 0 ? 12'h0AA : (i % 3 == 1 ? 12'h0BB : 12'h0CC));
      b = sb_cnt;
      soft_start(0);
      wait_sb(b + 1);
      cur_tag = "R11";
      reg_wr(3'd0, 32'd0);      // ignored while busy
      reg_wr(3'd4, 32'h1);      // ignored while busy
      wait_sb(b + 7);
      reg_wr(3'd4, 32'h4);      // abort
      @(posedge clk); #1;
      chk(busy == 0, "R5 abort stops", busy, 0);
      chk(exp_q.size() == 0, "R11 loop kept cycling", exp_q.size(), 0);
      chk(empty_flag == 0, "R5 data retained", empty_flag, 0);
      cur_tag = "R5";
      reg_wr(3'd0, 32'd0);
      exp_q.push_back(12'h0AA); exp_q.push_back(12'h0BB); exp_q.push_back(12'h0CC);
      soft_start(0);
      wait_idle();
      chk(exp_q.size() == 0 && empty_flag, "R5 replay from start then consume", exp_q.size(), 0);

      // R12 flush, R10 overflow, R6 polling, R8 underrun
      load(12'h123, 0);
      reg_wr(3'd4, 32'h8);
      chk(empty_flag == 1, "R12 flush empties", empty_flag, 1);
      cur_tag = "R10";
      for (int i = 0; i < DEPTH + 4; i++) load(12'h200 + 12'(i * 5), i < DEPTH);
      last_v = 12'h200 + 12'((DEPTH - 1) * 5);
      chk(half_flag == 0 && empty_flag == 0, "R6 full flags", {half_flag, empty_flag}, 0);
      reg_wr(3'd0, 32'd2);
      b = sb_cnt;
      soft_start(0);
      wait_sb(b + 7);
      chk(half_flag == 0, "R6 half after 7", half_flag, 0);
      wait_sb(b + 8);
      chk(half_flag == 1, "R6 half after 8", half_flag, 1);
      wait_sb(b + DEPTH);
      repeat (10) @(posedge clk); #1;
      chk(exp_q.size() == 0, "R10 overflow dropped", exp_q.size(), 0);
      chk(underrun == 1, "R8 underrun set", underrun, 1);
      chk(irq == 0, "R6 no irq in polling", irq, 0);
      chk(dac_data == last_v, "R8 hold last sample", dac_data, last_v);
      chk(busy == 1, "R8 streaming continues", busy, 1);
      reg_wr(3'd4, 32'h4);
      @(posedge clk); #1;
      chk(underrun == 1, "R8 sticky after abort", underrun, 1);
      reg_wr(3'd4, 32'h2);
      @(posedge clk); #1;
      chk(underrun == 0, "R8 ack clears", underrun, 0);

      // R7 interrupt mode
      cur_tag = "R7";
      reg_wr(3'd2, 32'd5);
      exp_per = 5;
      reg_wr(3'd0, 32'd3);
      for (int i = 0; i < DEPTH; i++) load(12'h700 + 12'(i * 3), 1);
      b = sb_cnt;
      soft_start(0);
      wait_sb(b + 7);
      chk(irq == 0, "R7 irq low after 7", irq, 0);
      wait_sb(b + 8);
      chk(irq == 1, "R7 irq at half", irq, 1);
      wait_sb(b + 9);
      chk(irq == 1, "R7 irq sticky", irq, 1);
      reg_wr(3'd4, 32'h2);
      @(posedge clk); #1;
      chk(irq == 0, "R7 ack clears irq", irq, 0);
      wait_sb(b + DEPTH);
      reg_wr(3'd4, 32'h4);
      reg_wr(3'd4, 32'h2);
      chk(exp_q.size() == 0, "R7 stream complete", exp_q.size(), 0);

      // R9 external trigger
      cur_tag = "R9";
      reg_wr(3'd0, 32'd0);
      reg_wr(3'd1, 32'd1);
      reg_wr(3'd2, 32'd4);
      exp_per = 4;
      load(12'h9A1, 0); load(12'h9A2, 0);
      b = sb_cnt;
      ext_pulse(1, 0);
      repeat (30) @(posedge clk); #1;
      chk(busy == 0 && sb_cnt == b, "R9 ignored when disabled", busy, 0);
      reg_wr(3'd0, 32'h4);
      exp_q.push_back(12'h9A1); exp_q.push_back(12'h9A2);
      ext_pulse(1, 1);
      wait_idle();
      chk(exp_q.size() == 0, "R9 external start played", exp_q.size(), 0);

      summary();
      $finish;
   end
endmodule